// File: doc/BRIEF.md
# Pipelined CORDIC Rectangular-to-Polar Converter

This block turns a signed Cartesian pair into polar form: a magnitude and an angle. It accepts one new pair on every clock, and each result appears a fixed number of cycles later.

A fold stage mirrors any vector in the left half-plane into the right half-plane, where shift-and-add iterations converge. It records which half the vector came from. A chain of identical micro-rotation stages then drives the vector onto the positive x-axis. Each stage adds or subtracts a constant arctangent of a power of two to a running angle. A final stage restores the half-plane, rounds the angle, and rounds and clamps the magnitude.

The magnitude keeps the CORDIC gain and is not compensated. A qualifier bit travels beside each sample through every register.

Top module: `cordic_polar`

## Requirements
- R1: `valid_o` is high exactly 18 cycles after each cycle in which `valid_i` was high, and low otherwise. The 18 cycles are one fold stage, 16 rotation stages and one output stage.
- R2: While `rst_ni` is low, and after its release until a sample has traversed the pipeline, `valid_o` is low.
- R3: For inputs with `x_i` >= 0, `mag_o` equals hypot(x, y) multiplied by the product over i=0..15 of sqrt(1+2^-2i) (about 1.64676). It is expressed as an unsigned number with 4 fractional bits (value times 16), within 8 LSB.
- R4: `ang_o` is a two's complement angle in which 32768 LSB represent pi (one LSB is pi/32768). It equals atan2(y, x) within 6 + 2000/hypot(x, y) LSB, with the difference taken modulo 65536.
- R5: Inputs with `x_i` < 0 give magnitude and angle to the same rules as R3 and R4. This includes `x_i` = -32768.
- R6: Axis inputs with a nonzero length a give these angles: (+a, 0) gives 0, (0, +a) gives 16384, (0, -a) gives -16384, and (-a, 0) gives -32768, which stands for pi.
- R7: When the gained magnitude times 16 exceeds 1048575, `mag_o` is clamped to 1048575 (all ones).
- R8: The input (0, 0) gives `mag_o` = 0. The angle for this input is not specified.
- R9: Samples presented on consecutive cycles or separated by idle cycles emerge in order, one result per accepted sample, each independent of its neighbours.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Input pair is valid this cycle |
| x_i | input | 16 | Signed x coordinate |
| y_i | input | 16 | Signed y coordinate |
| valid_o | output | 1 | Result is valid this cycle |
| mag_o | output | 20 | Unsigned gained magnitude, 16 integer and 4 fractional bits |
| ang_o | output | 16 | Signed angle, 32768 LSB = pi |

## Verification
The hardest cases to reach are the far edges of the input range. One is the most negative x, whose negation needs an extra bit. Another is the corners of the square, where the gained length overflows 20 bits and must clamp. A third is very short vectors, whose angle precision collapses. Random 16-bit pairs seldom land on these, so directed vectors cover each one: the axes, the pair (-32768, 0), the four full-scale corners, a zero vector and unit vectors. The random stream mixes back-to-back samples with idle gaps, so ordering and latency are also checked under full throughput.

// File: rtl/cordic_pkg.sv
package cordic_pkg;

  // atan(2^-i) scaled so that 2^23 represents pi
  function automatic logic [31:0] atan_pi23(input int i);
    case (i)
      0:  return 32'd2097152;
      1:  return 32'd1238022;
      2:  return 32'd654136;
      3:  return 32'd332050;
      4:  return 32'd166669;
      5:  return 32'd83415;
      6:  return 32'd41718;
      7:  return 32'd20860;
      8:  return 32'd10430;
      9:  return 32'd5215;
      10: return 32'd2608;
      11: return 32'd1304;
      12: return 32'd652;
      13: return 32'd326;
      14: return 32'd163;
      15: return 32'd81;
      16: return 32'd41;
      17: return 32'd20;
      18: return 32'd10;
      19: return 32'd5;
      20: return 32'd3;
      21: return 32'd1;
      22: return 32'd1;
      default: return 32'd0;
    endcase
  endfunction

  // rescale table entry to an accumulator where 2^(zw-1) represents pi
  function automatic logic [31:0] atan_step(input int i, input int zw);
    logic [31:0] v;
    v = atan_pi23(i);
    if (zw - 1 <= 23) return v >> (23 - (zw - 1));
    else              return v << ((zw - 1) - 23);
  endfunction

endpackage

// File: rtl/cordic_pre.sv
module cordic_pre #(
  parameter int DATA_W = 16,
  parameter int FG_W   = 8,
  parameter int W      = 26
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [DATA_W-1:0]        x_i,
  input  logic [DATA_W-1:0]        y_i,
  output logic                     vld_o,
  output logic                     half_o,
  output logic signed [W-1:0]      x_o,
  output logic signed [W-1:0]      y_o
);
  localparam int EXT_W = W - DATA_W - FG_W;

  logic signed [W-1:0] x_ext, y_ext;
  logic                neg_x;

  assign x_ext = {{EXT_W{x_i[DATA_W-1]}}, x_i, {FG_W{1'b0}}};
  assign y_ext = {{EXT_W{y_i[DATA_W-1]}}, y_i, {FG_W{1'b0}}};
  assign neg_x = x_i[DATA_W-1];

  // mirror left half-plane through the origin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      half_o <= 1'b0;
      x_o    <= '0;
      y_o    <= '0;
    end else begin
      vld_o  <= valid_i;
      half_o <= neg_x;
      x_o    <= neg_x ? -x_ext : x_ext;
      y_o    <= neg_x ? -y_ext : y_ext;
    end
  end

  AST_FOLD_RIGHT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> !x_o[W-1]); // R5
  AST_ZERO_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && x_i == '0 && y_i == '0) |=> (x_o == '0 && y_o == '0)); // R8

endmodule

// File: rtl/cordic_stage.sv
module cordic_stage #(
  parameter int W     = 26,
  parameter int ZW    = 24,
  parameter int SHIFT = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 half_i,
  input  logic signed [W-1:0]  x_i,
  input  logic signed [W-1:0]  y_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 vld_o,
  output logic                 half_o,
  output logic signed [W-1:0]  x_o,
  output logic signed [W-1:0]  y_o,
  output logic signed [ZW-1:0] z_o
);
  localparam logic signed [ZW-1:0] STEP = ZW'(cordic_pkg::atan_step(SHIFT, ZW));

  logic signed [W-1:0] x_sh, y_sh;
  assign x_sh = x_i >>> SHIFT;
  assign y_sh = y_i >>> SHIFT;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      half_o <= 1'b0;
      x_o    <= '0;
      y_o    <= '0;
      z_o    <= '0;
    end else begin
      vld_o  <= vld_i;
      half_o <= half_i;
      if (!y_i[W-1]) begin
        x_o <= x_i + y_sh;
        y_o <= y_i - x_sh;
        z_o <= z_i + STEP;
      end else begin
        x_o <= x_i - y_sh;
        y_o <= y_i + x_sh;
        z_o <= z_i - STEP;
      end
    end
  end

  AST_X_NONNEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> !x_o[W-1]); // R3

endmodule

// File: rtl/cordic_post.sv
module cordic_post #(
  parameter int W      = 26,
  parameter int ZW     = 24,
  parameter int GUARD  = 4,
  parameter int MAG_W  = 20,
  parameter int ANG_W  = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 vld_i,
  input  logic                 half_i,
  input  logic signed [W-1:0]  x_i,
  input  logic signed [ZW-1:0] z_i,
  output logic                 valid_o,
  output logic [MAG_W-1:0]     mag_o,
  output logic [ANG_W-1:0]     ang_o
);
  localparam int               RW      = W - GUARD;
  localparam logic [ZW-1:0]    PI_Z    = {1'b1, {(ZW-1){1'b0}}};
  localparam logic [ZW-1:0]    ANG_RND = ZW'(1) << (ZW - ANG_W - 1);
  localparam logic [W-1:0]     MAG_RND = W'(1) << (GUARD - 1);

  logic [ZW-1:0] z_full, z_rnd;
  logic [W-1:0]  x_rnd;
  logic [RW-1:0] mag_wide;
  logic          ovf;

  // adding pi equals subtracting pi modulo a full turn
  assign z_full   = half_i ? (z_i + PI_Z) : z_i;
  assign z_rnd    = z_full + ANG_RND;
  assign x_rnd    = x_i + MAG_RND;
  assign mag_wide = x_rnd[W-1:GUARD];
  assign ovf      = |mag_wide[RW-1:MAG_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      mag_o   <= '0;
      ang_o   <= '0;
    end else begin
      valid_o <= vld_i;
      mag_o   <= ovf ? {MAG_W{1'b1}} : mag_wide[MAG_W-1:0];
      ang_o   <= z_rnd[ZW-1 -: ANG_W];
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i |=> valid_o); // R1

endmodule

// File: rtl/cordic_polar.sv
module cordic_polar #(
  parameter int DATA_W = 16,
  parameter int FRAC_W = 4,
  parameter int GUARD  = 4,
  parameter int STAGES = 16,
  parameter int ANG_W  = 16
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      valid_i,
  input  logic [DATA_W-1:0]         x_i,
  input  logic [DATA_W-1:0]         y_i,
  output logic                      valid_o,
  output logic [DATA_W+FRAC_W-1:0]  mag_o,
  output logic [ANG_W-1:0]          ang_o
);
  localparam int FG_W  = FRAC_W + GUARD;
  localparam int W     = DATA_W + 2 + FG_W;
  localparam int ZW    = ANG_W + 8;
  localparam int MAG_W = DATA_W + FRAC_W;
  localparam int LAT   = STAGES + 2;
  localparam int CW    = $clog2(LAT + 2) + 1;

  logic                 vld_s  [STAGES+1];
  logic                 half_s [STAGES+1];
  logic signed [W-1:0]  x_s    [STAGES+1];
  logic signed [W-1:0]  y_s    [STAGES+1];
  logic signed [ZW-1:0] z_s    [STAGES+1];

  cordic_pre #(.DATA_W(DATA_W), .FG_W(FG_W), .W(W)) u_pre (
    .clk_i (clk_i), .rst_ni(rst_ni), .valid_i(valid_i),
    .x_i   (x_i),   .y_i   (y_i),
    .vld_o (vld_s[0]), .half_o(half_s[0]), .x_o(x_s[0]), .y_o(y_s[0])
  );
  assign z_s[0] = '0;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    cordic_stage #(.W(W), .ZW(ZW), .SHIFT(g)) u_stage (
      .clk_i (clk_i),      .rst_ni(rst_ni),
      .vld_i (vld_s[g]),   .half_i(half_s[g]),
      .x_i   (x_s[g]),     .y_i   (y_s[g]),   .z_i(z_s[g]),
      .vld_o (vld_s[g+1]), .half_o(half_s[g+1]),
      .x_o   (x_s[g+1]),   .y_o   (y_s[g+1]), .z_o(z_s[g+1])
    );
  end

  cordic_post #(.W(W), .ZW(ZW), .GUARD(GUARD), .MAG_W(MAG_W), .ANG_W(ANG_W)) u_post (
    .clk_i  (clk_i),          .rst_ni(rst_ni),
    .vld_i  (vld_s[STAGES]),  .half_i(half_s[STAGES]),
    .x_i    (x_s[STAGES]),    .z_i   (z_s[STAGES]),
    .valid_o(valid_o),        .mag_o (mag_o), .ang_o(ang_o)
  );

  // checker state: cycles since the last accepted sample, saturating
  logic [CW-1:0] idle_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     idle_cnt <= CW'(LAT + 1);
    else if (valid_i)                idle_cnt <= '0;
    else if (idle_cnt < CW'(LAT + 1)) idle_cnt <= idle_cnt + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_cnt > CW'(LAT)) |-> !valid_o); // R1
  AST_TABLE_FITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |-> (STAGES <= 23)); // R4

endmodule

// File: tb/cordic_polar_test.sv
module cordic_polar_test;
  localparam int CLK_P  = 10;
  localparam int LAT    = 18;
  localparam int NMAX   = 2048;
  localparam int NRAND  = 1500;
  localparam real PI    = 3.14159265358979;
  localparam int MAGMAX = 1048575;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        valid_i = 0;
  logic [15:0] x_i = '0, y_i = '0;
  logic        valid_o;
  logic [19:0] mag_o;
  logic [15:0] ang_o;

  cordic_polar uut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .x_i(x_i), .y_i(y_i),
    .valid_o(valid_o), .mag_o(mag_o), .ang_o(ang_o)
  );

  always #(CLK_P/2) clk = ~clk;

  int  n_chk = 0, n_fail = 0;
  int  cyc = 0;
  int  n_in = 0, k_out = 0;
  int  xs [NMAX];
  int  ys [NMAX];
  int  cin [NMAX];
  bit  mon_on = 0;
  bit  done = 0;
  real gain;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic string tag_of(int x, int y, real mexp);
    if (x == 0 && y == 0)        return "R8";
    if (mexp > MAGMAX)           return "R7";
    if (x == 0 || y == 0)        return "R6";
    if (x < 0)                   return "R5";
    return "R3";
  endfunction

  task automatic add_vec(int x, int y);
    xs[n_in] = x; ys[n_in] = y;
    @(negedge clk);
    valid_i = 1; x_i = 16'(x); y_i = 16'(y);
    cin[n_in] = cyc;
    n_in++;
    @(negedge clk);
    valid_i = 0;
  endtask

  task automatic add_stream(int x, int y);
    xs[n_in] = x; ys[n_in] = y;
    valid_i = 1; x_i = 16'(x); y_i = 16'(y);
    cin[n_in] = cyc;
    n_in++;
    @(negedge clk);
  endtask

  // output monitor
  always @(negedge clk) begin
    if (mon_on && valid_o) begin
      if (k_out >= n_in) begin
        n_chk++; n_fail++;
        $display("FAIL R9 extra output: got valid, expected none");
      end else begin
        int  x, y, dl, ge, dg, tol_a;
        real h, mexp, aexp, diff;
        string t;
        x = xs[k_out]; y = ys[k_out];
        h = $hypot(real'(x), real'(y));
        mexp = h * gain * 16.0;
        t = tag_of(x, y, mexp);
        if (mexp > MAGMAX) mexp = MAGMAX;
        // R1 latency
        n_chk++;
        dl = cyc - cin[k_out];
        if (dl != LAT) begin
          n_fail++;
          $display("FAIL R1 latency vec %0d: got %0d expected %0d", k_out, dl, LAT);
        end
        // R3/R5/R7/R8 magnitude
        n_chk++;
        diff = real'(int'(mag_o)) - mexp;
        if (diff > 8.0 || diff < -8.0) begin
          n_fail++;
          $display("FAIL %s mag vec %0d (%0d,%0d): got %0d expected %0.1f", t, k_out, x, y, mag_o, mexp);
        end
        // R4 angle, modulo a full turn
        if (!(x == 0 && y == 0)) begin
          n_chk++;
          aexp = $atan2(real'(y), real'(x)) / PI * 32768.0;
          ge = int'($signed(ang_o));
          diff = real'(ge) - aexp;
          while (diff >= 32768.0) diff -= 65536.0;
          while (diff < -32768.0) diff += 65536.0;
          tol_a = 6 + int'(2000.0 / h);
          dg = int'(diff);
          if (dg > tol_a || dg < -tol_a) begin
            n_fail++;
            $display("FAIL R4/%s ang vec %0d (%0d,%0d): got %0d expected %0.1f", t, k_out, x, y, ge, aexp);
          end
        end
      end
      k_out++;
    end
  end

  // watchdog
  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    gain = 1.0;
    for (int i = 0; i < 16; i++) gain = gain * $sqrt(1.0 + 2.0 ** (-2.0 * i));

    // R2 reset state
    repeat (3) @(negedge clk);
    n_chk++;
    if (valid_o !== 1'b0) begin
      n_fail++; $display("FAIL R2 during reset: got %b expected 0", valid_o);
    end
    rst_n = 1;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      n_chk++;
      if (valid_o !== 1'b0) begin
        n_fail++; $display("FAIL R2 after reset: got %b expected 0", valid_o);
      end
    end
    mon_on = 1;

    // directed: axes R6, fold edge R5, corners R7, zero R8, short vectors
    add_vec(20000, 0);
    add_vec(0, 20000);
    add_vec(0, -20000);
    add_vec(-20000, 0);
    add_vec(-32768, 0);
    add_vec(-32768, 12345);
    add_vec(32767, 32767);
    add_vec(-32768, -32768);
    add_vec(32767, -32768);
    add_vec(-32768, 32767);
    add_vec(0, 0);
    add_vec(1, 0);
    add_vec(0, -1);
    add_vec(-1, 0);
    add_vec(1000, 1000);
    add_vec(-1000, 1000);
    add_vec(-1000, -1000);
    add_vec(1000, -1000);
    add_vec(30000, 1);
    add_vec(-30000, -1);

    // R9 random stream with idle gaps
    for (int i = 0; i < NRAND; i++) begin
      int x, y;
      x = int'($signed(16'($urandom)));
      y = int'($signed(16'($urandom)));
      if (($urandom % 4) == 0) begin
        valid_i = 0;
        repeat ($urandom % 3 + 1) @(negedge clk);
      end
      add_stream(x, y);
    end
    valid_i = 0;

    while (k_out < n_in) @(negedge clk);
    repeat (LAT + 5) @(negedge clk);
    n_chk++;
    if (k_out != n_in) begin
      n_fail++; $display("FAIL R9 result count: got %0d expected %0d", k_out, n_in);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule